// File: doc/BRIEF.md
# Write-Once Bridge Setup Register with Key Unlock

This block holds the 32-bit setup word of a bus bridge. Boot firmware stores it once after reset; from then on the word is sealed and can only be read. A companion unlock register takes a key byte. When the key matches, the setup word is opened for exactly one more write, and it seals itself again once that write has landed. Until the first write, the block keeps its `cfg_ready` output low, and the bridge uses this flag to hold off external bus cycles.

The block also answers the register bus when an access is blocked. An access is blocked when it is a write to the sealed setup word, or when it goes to an offset that maps to neither register. The abort-enable bit of the setup word selects the answer. When the bit is set, a blocked access ends with an abort response. When it is clear, a blocked write is dropped without notice and a blocked read returns zero. Any write to the sealed word also raises a one-cycle `wr_ignored` pulse.

Top module: `boot_cfg_lock`

## Requirements
- R1: After reset, the setup word reads 0x0CC0_0000: bits 27, 26, 23 and 22 are 1 and every other bit is 0. The unlock register reads 0 and `cfg_ready` is low.
- R2: The first setup write after reset is stored, with bit 31 forced to 0. It raises neither `wr_ignored` nor `reg_abort`.
- R3: Once the setup word is sealed, a write to it leaves the stored value unchanged. The write produces a `wr_ignored` pulse exactly one cycle long.
- R4: Bit 31 of the setup word always reads 0.
- R5: A write to the unlock register whose bits [7:0] equal 0xCA, made while the word is sealed, sets the pending flag (unlock read-back bit 0). The next setup write is then stored, the pending flag clears, and the word is sealed again.
- R6: The pending flag is left unchanged by an unlock write whose bits [7:0] are not 0xCA, and by a key write made before the first setup write. A second key write while a grant is already pending grants no extra write. Only bits [7:0] of an unlock write are compared; the upper bits are ignored.
- R7: When setup bit 24 is 1, a blocked access (a write to the sealed word, or any access to an unmapped offset) returns `reg_abort` = 1, and read data of 0.
- R8: When setup bit 24 is 0, a blocked access returns `reg_abort` = 0. A blocked read returns 0 and a blocked write has no effect.
- R9: Reads of either register work in every lock state and do not change the setup word or the pending flag.
- R10: Holding `rst_n` low at a clock edge restores the default value, the unwritten state and `cfg_ready` = 0, and clears any pending grant.
- R11: `cfg_ready` rises in the cycle after the first setup write and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Byte offset: the setup word is at 0x00 and the unlock register at 0x04 |
| reg_wr | input | 1 | Write strobe; takes priority over `reg_rd` |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered; 0 when no read was made |
| reg_abort | output | 1 | Abort response for a blocked access, registered |
| wr_ignored | output | 1 | One-cycle pulse after a write to the sealed setup word |
| cfg_ready | output | 1 | High once the setup word has been written |

## Verification
Every response is registered. Read data, `reg_abort` and `wr_ignored` for an access presented before clock edge k are valid just after edge k, and they return to their idle values at edge k+1. A write to the setup word updates both the stored value and `cfg_ready` at that same edge k. The bench drives each access on the falling edge, waits for the next rising edge, and samples 1 ns later. It checks `wr_ignored` again one idle cycle later to confirm that the pulse lasts one cycle. Lock-state effects are observed by reading back the pending bit and the setup word.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam logic [31:0] SETUP_RST   = 32'h0CC0_0000;
  localparam logic [31:0] SETUP_WMASK = 32'h7FFF_FFFF;
  localparam int          TA_BIT      = 24;
  localparam logic [7:0]  UNLOCK_KEY  = 8'hCA;

  typedef enum logic [1:0] {
    LK_FRESH  = 2'd0,
    LK_SEALED = 2'd1,
    LK_ONCE   = 2'd2
  } lock_e;

  function automatic logic [31:0] setup_merge(input logic [31:0] w);
    return w & SETUP_WMASK;
  endfunction

  function automatic logic key_hit(input logic [31:0] w);
    return w[7:0] == UNLOCK_KEY;
  endfunction
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import boot_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic setup_wr,
  input  logic unlock_wr,
  input  logic key_ok,
  output logic accept,
  output logic blocked,
  output logic pending,
  output logic ready
);
  lock_e state;

  always_comb begin
    accept  = setup_wr && (state != LK_SEALED);
    blocked = setup_wr && (state == LK_SEALED);
    pending = (state == LK_ONCE);
    ready   = (state != LK_FRESH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= LK_FRESH;
    end else begin
      case (state)
        LK_FRESH:  if (setup_wr) state <= LK_SEALED;
        LK_SEALED: if (unlock_wr && key_ok) state <= LK_ONCE;
        LK_ONCE:   if (setup_wr) state <= LK_SEALED;
        default:   state <= LK_SEALED;
      endcase
    end
  end

  // R5
  once_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && setup_wr) |=> (!pending && ready));

  // R11
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/cfg_setup_store.sv
module cfg_setup_store
  import boot_cfg_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] RST_VAL = SETUP_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= setup_merge(wdata);
  end

  // R4
  bit31_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q[DW-1]);
endmodule

// File: rtl/cfg_rsp_gen.sv
module cfg_rsp_gen #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          hit_setup,
  input  logic          hit_unlock,
  input  logic          blocked,
  input  logic          en_ta,
  input  logic          pending,
  input  logic [DW-1:0] setup_q,
  output logic [DW-1:0] rdata,
  output logic          abort,
  output logic          ignored
);
  logic          unmapped;
  logic          restricted;
  logic          rd_only;
  logic [DW-1:0] rdata_d;

  always_comb begin
    unmapped   = !hit_setup && !hit_unlock;
    rd_only    = rd && !wr;
    restricted = (wr && (blocked || unmapped)) || (rd_only && unmapped);
    rdata_d    = '0;
    if (rd_only && hit_setup)  rdata_d = setup_q;
    if (rd_only && hit_unlock) rdata_d = {{(DW-1){1'b0}}, pending};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      abort   <= 1'b0;
      ignored <= 1'b0;
    end else begin
      rdata   <= rdata_d;
      abort   <= restricted && en_ta;
      ignored <= blocked;
    end
  end

  // R7
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (rdata == '0));
endmodule

// File: rtl/boot_cfg_lock.sv
module boot_cfg_lock
  import boot_cfg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SETUP_OFS  = 0,
  parameter int UNLOCK_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_abort,
  output logic              wr_ignored,
  output logic              cfg_ready
);
  localparam int DW = 32;

  logic          hit_setup, hit_unlock;
  logic          setup_wr_evt, unlock_wr_evt;
  logic          accept, blocked, pending;
  logic [DW-1:0] setup_q;

  assign hit_setup     = (reg_addr == ADDR_W'(SETUP_OFS));
  assign hit_unlock    = (reg_addr == ADDR_W'(UNLOCK_OFS));
  assign setup_wr_evt  = reg_wr && hit_setup;
  assign unlock_wr_evt = reg_wr && hit_unlock;

  cfg_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr_evt),
    .unlock_wr(unlock_wr_evt), .key_ok(key_hit(reg_wdata)),
    .accept(accept), .blocked(blocked), .pending(pending), .ready(cfg_ready)
  );

  cfg_setup_store #(.DW(DW), .RST_VAL(SETUP_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .load(accept), .wdata(reg_wdata), .q(setup_q)
  );

  cfg_rsp_gen #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
    .hit_setup(hit_setup), .hit_unlock(hit_unlock), .blocked(blocked),
    .en_ta(setup_q[TA_BIT]), .pending(pending), .setup_q(setup_q),
    .rdata(reg_rdata), .abort(reg_abort), .ignored(wr_ignored)
  );

  // R3
  sealed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(setup_q));

  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> $past(setup_wr_evt));
endmodule

// File: tb/sim_boot_cfg_lock.sv
`timescale 1ns/1ps
module sim_boot_cfg_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_abort, wr_ignored, cfg_ready;
  int n_chk = 0, n_fail = 0;

  localparam logic [7:0] A_SET = 8'h00, A_UNL = 8'h04, A_BAD = 8'h10;

  always #2.5 clk = ~clk;

  boot_cfg_lock u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_abort(reg_abort), .wr_ignored(wr_ignored), .cfg_ready(cfg_ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    @(posedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0;
    @(posedge clk); #1; reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_rd(A_SET); check("R1 setup default", reg_rdata, 32'h0CC0_0000);
    do_rd(A_UNL); check("R1 unlock default", reg_rdata, 32'h0);
    check("R1 ready low", {31'b0, cfg_ready}, 32'h0);
  endtask

  task automatic t_unlock_before_write();
    do_wr(A_UNL, 32'h0000_00CA);
    do_rd(A_UNL); check("R6 key while unwritten", reg_rdata, 32'h0);
  endtask

  task automatic t_first_write();
    do_wr(A_SET, 32'h8012_3456);
    check("R2 no ignore", {31'b0, wr_ignored}, 32'h0);
    check("R2 no abort", {31'b0, reg_abort}, 32'h0);
    check("R11 ready up", {31'b0, cfg_ready}, 32'h1);
    do_rd(A_SET); check("R2 R4 stored masked", reg_rdata, 32'h0012_3456);
  endtask

  task automatic t_sealed_write();
    do_wr(A_SET, 32'h1111_1111);
    check("R3 ignore pulse", {31'b0, wr_ignored}, 32'h1);
    check("R8 no abort", {31'b0, reg_abort}, 32'h0);
    @(negedge clk);
    @(posedge clk); #1;
    check("R3 pulse one cycle", {31'b0, wr_ignored}, 32'h0);
    do_rd(A_SET); check("R3 value held", reg_rdata, 32'h0012_3456);
  endtask

  task automatic t_unmapped_quiet();
    do_rd(A_BAD);
    check("R8 unmapped read zero", reg_rdata, 32'h0);
    check("R8 unmapped no abort", {31'b0, reg_abort}, 32'h0);
    do_wr(A_BAD, 32'hFFFF_FFFF);
    check("R8 unmapped write no abort", {31'b0, reg_abort}, 32'h0);
  endtask

  task automatic t_bad_key();
    do_wr(A_UNL, 32'h0000_0035);
    do_rd(A_UNL); check("R6 wrong key", reg_rdata, 32'h0);
    do_wr(A_UNL, 32'h0000_CA00);
    do_rd(A_UNL); check("R6 key in wrong byte", reg_rdata, 32'h0);
  endtask

  task automatic t_one_shot();
    do_wr(A_UNL, 32'hFFFF_FFCA);
    do_rd(A_UNL); check("R5 pending set", reg_rdata, 32'h1);
    do_wr(A_UNL, 32'h0000_00CA);
    do_rd(A_SET); check("R9 read keeps value", reg_rdata, 32'h0012_3456);
    do_rd(A_UNL); check("R9 read keeps pending", reg_rdata, 32'h1);
    do_wr(A_SET, 32'h0100_00AB);
    check("R5 granted write not ignored", {31'b0, wr_ignored}, 32'h0);
    do_rd(A_SET); check("R5 granted write stored", reg_rdata, 32'h0100_00AB);
    do_rd(A_UNL); check("R5 pending cleared", reg_rdata, 32'h0);
    do_wr(A_SET, 32'h0000_0001);
    check("R6 no double grant", {31'b0, wr_ignored}, 32'h1);
    check("R7 sealed write abort", {31'b0, reg_abort}, 32'h1);
    do_rd(A_SET); check("R6 value after extra key", reg_rdata, 32'h0100_00AB);
  endtask

  task automatic t_abort_unmapped();
    do_rd(A_BAD);
    check("R7 unmapped abort", {31'b0, reg_abort}, 32'h1);
    check("R7 unmapped data zero", reg_rdata, 32'h0);
  endtask

  task automatic t_reset_clears();
    do_wr(A_UNL, 32'h0000_00CA);
    do_reset();
    check("R10 ready cleared", {31'b0, cfg_ready}, 32'h0);
    do_rd(A_UNL); check("R10 pending cleared", reg_rdata, 32'h0);
    do_rd(A_SET); check("R10 default restored", reg_rdata, 32'h0CC0_0000);
    do_wr(A_SET, 32'h0000_0F0F);
    check("R10 writable again", {31'b0, wr_ignored}, 32'h0);
    do_rd(A_SET); check("R10 value stored", reg_rdata, 32'h0000_0F0F);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_unlock_before_write();
    t_first_write();
    t_sealed_write();
    t_unmapped_quiet();
    t_bad_key();
    t_one_shot();
    t_abort_unmapped();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule